// File: doc/BRIEF.md
# Peripheral Bus I/O Instruction Sequencer

This block carries out the single-word transfer instructions of a 16-bit accumulator processor on a shared peripheral bus. The core hands it an I/O instruction word together with the current accumulator. The block then runs one bus transaction:

- It places a function code and a device code on the address bus.
- It waits a fixed number of settle cycles.
- It samples the device ready line.
- It emits at most one single-cycle strobe.
- It returns the new accumulator value and the program counter increment.

Execution never stalls on a slow device. If the device is not ready, the instruction falls through with an increment of 1. If the device is ready, the data moves, a reset-ready acknowledge strobe fires, and the next instruction is skipped with an increment of 2. Software polls by looping on the instruction that follows. The control pulse and mask-set instructions need no reply from the device. They always fall through.

Bits are numbered here in vector order, `[15]` most significant. The opcode is `instr[15:10]`. The function code is `instr[9:6]`, and `instr[9]` is the clear-first flag for input. The device code is `instr[5:0]`.

Top module: `iobus_seq`

## Requirements
- R1: From the cycle after an accepted start through the done cycle, `adb_o` equals `instr[9:0]`: function code in `adb_o[9:6]` and device code in `adb_o[5:0]`. It holds steady for that whole window. While the block is idle, `adb_o` is zero.
- R2: `done_o` is a one-cycle pulse in the cycle after the `SETTLE_CYC+2`-th rising edge counted from the edge that accepts `start_i`. `busy_o` is high from that accept edge through the done cycle. `ready_i` is sampled only on the edge just before `done_o` rises.
- R3: Opcode 6'o54 is input. When the device is ready, the new accumulator is `inb_i` if `instr[9]` is 1, and `acc_i | inb_i` otherwise. In the ready case `ack_o` pulses and `pc_inc_o` is 2.
- R4: Input with the device not ready returns `acc_i` unchanged and `pc_inc_o` 1, with no strobe.
- R5: Opcode 6'o74 with a device code other than `MASK_DEV` is output. `otb_o` carries `acc_i` while busy. When the device is ready, `ack_o` pulses and `pc_inc_o` is 2. When it is not ready, there is no strobe and `pc_inc_o` is 1.
- R6: Opcode 6'o74 with device code equal to `MASK_DEV` (default 0) is mask-set. `otb_o` carries `acc_i`, `mask_o` pulses, and `pc_inc_o` is 1 whatever the state of `ready_i`.
- R7: Opcode 6'o14 is control pulse. `ctl_o` pulses and `pc_inc_o` is 1 whatever the state of `ready_i`.
- R8: Opcode 6'o34 is skip test. `pc_inc_o` is 2 when ready and 1 otherwise, and no strobe fires.
- R9: A strobe (`ack_o`, `ctl_o`, `mask_o`) is high only in the done cycle and lasts one clock. At most one strobe is high at a time.
- R10: Any other opcode gives no strobe, `pc_inc_o` 1 and the accumulator unchanged. `otb_o` is zero whenever the operation is neither output nor mask-set.
- R11: A `start_i` seen while busy is ignored. The running instruction's results are unchanged.
- R12: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (taken when idle) |
| instr_i | input | 16 | I/O instruction word |
| acc_i | input | 16 | Accumulator value at start |
| ready_i | input | 1 | Device ready line |
| inb_i | input | 16 | Device input bus |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Results valid, one cycle |
| acc_o | output | 16 | New accumulator value |
| pc_inc_o | output | 2 | Program counter increment (1 or 2) |
| adb_o | output | 10 | Address bus: function and device code |
| otb_o | output | 16 | Output bus |
| ack_o | output | 1 | Reset-ready acknowledge strobe |
| ctl_o | output | 1 | Control pulse strobe |
| mask_o | output | 1 | Mask-set strobe |

## Verification
The bench builds the block with its default widths, `SETTLE_CYC` of 2 and `MASK_DEV` of 0. These values keep the whole opcode decode and the ready branch small enough for a full cross product. The cross covers four bus opcodes plus two undefined ones, three function codes (clear flag on and off) and three device codes (including the mask device), each with ready high and low. Every combination is run with its own accumulator and input patterns. Expected results, strobe positions and done timing are computed from the requirements. A second start issued mid-transaction covers the ignore rule.

// File: rtl/iobus_pkg.sv
package iobus_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_IN, OP_OUT, OP_CTL, OP_MASK, OP_SKS} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_EXEC, ST_FIN} st_e;
  localparam logic [5:0] OPC_IN  = 6'o54;
  localparam logic [5:0] OPC_OUT = 6'o74;
  localparam logic [5:0] OPC_CTL = 6'o14;
  localparam logic [5:0] OPC_SKS = 6'o34;
endpackage

// File: rtl/iobus_decode.sv
module iobus_decode
  import iobus_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned FUNC_W = 4,
  parameter int unsigned DEV_W  = 6,
  parameter logic [DEV_W-1:0] MASK_DEV = '0
) (
  input  logic [WORD_W-1:0] instr_i,
  output op_e               op_o,
  output logic              clr_o
);
  localparam int unsigned ADDR_W = FUNC_W + DEV_W;
  localparam int unsigned OPC_W  = WORD_W - ADDR_W;

  logic [OPC_W-1:0] opc;
  logic [DEV_W-1:0] dev;

  assign opc   = instr_i[WORD_W-1 -: OPC_W];
  assign dev   = instr_i[DEV_W-1:0];
  assign clr_o = instr_i[ADDR_W-1];

  always_comb begin
    op_o = OP_NONE;
    if (opc == OPC_IN[OPC_W-1:0])       op_o = OP_IN;
    else if (opc == OPC_OUT[OPC_W-1:0]) op_o = (dev == MASK_DEV) ? OP_MASK : OP_OUT;
    else if (opc == OPC_CTL[OPC_W-1:0]) op_o = OP_CTL;
    else if (opc == OPC_SKS[OPC_W-1:0]) op_o = OP_SKS;
  end
endmodule

// File: rtl/iobus_settle.sv
module iobus_settle #(
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!last_o) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/iobus_exec.sv
module iobus_exec
  import iobus_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  op_e               op_i,
  input  logic              clr_i,
  input  logic              ready_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] inb_i,
  output logic [WORD_W-1:0] acc_o,
  output logic [1:0]        pc_inc_o,
  output logic              ack_o,
  output logic              ctl_o,
  output logic              mask_o
);
  always_comb begin
    acc_o    = acc_i;
    pc_inc_o = 2'd1;
    ack_o    = 1'b0;
    ctl_o    = 1'b0;
    mask_o   = 1'b0;
    unique case (op_i)
      OP_IN: if (ready_i) begin
        acc_o    = (clr_i ? '0 : acc_i) | inb_i;
        pc_inc_o = 2'd2;
        ack_o    = 1'b1;
      end
      OP_OUT: if (ready_i) begin
        pc_inc_o = 2'd2;
        ack_o    = 1'b1;
      end
      OP_CTL:  ctl_o  = 1'b1;
      OP_MASK: mask_o = 1'b1;
      OP_SKS:  if (ready_i) pc_inc_o = 2'd2;
      default: ;
    endcase
  end
endmodule

// File: rtl/iobus_seq.sv
module iobus_seq
  import iobus_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned FUNC_W     = 4,
  parameter int unsigned DEV_W      = 6,
  parameter int unsigned SETTLE_CYC = 2,
  parameter logic [DEV_W-1:0] MASK_DEV = '0,
  localparam int unsigned ADDR_W    = FUNC_W + DEV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              ready_i,
  input  logic [WORD_W-1:0] inb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [1:0]        pc_inc_o,
  output logic [ADDR_W-1:0] adb_o,
  output logic [WORD_W-1:0] otb_o,
  output logic              ack_o,
  output logic              ctl_o,
  output logic              mask_o
);
  st_e               st_q, st_d;
  op_e               op_q, op_dec;
  logic              clr_q, clr_dec;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] acc_q;
  logic              settle_last;
  logic [WORD_W-1:0] acc_new;
  logic [1:0]        inc_new;
  logic              ack_new, ctl_new, mask_new;

  iobus_decode #(
    .WORD_W(WORD_W), .FUNC_W(FUNC_W), .DEV_W(DEV_W), .MASK_DEV(MASK_DEV)
  ) i_decode (
    .instr_i(instr_i), .op_o(op_dec), .clr_o(clr_dec)
  );

  iobus_settle #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(st_q == ST_SETTLE), .last_o(settle_last)
  );

  iobus_exec #(.WORD_W(WORD_W)) i_exec (
    .op_i(op_q), .clr_i(clr_q), .ready_i(ready_i), .acc_i(acc_q), .inb_i(inb_i),
    .acc_o(acc_new), .pc_inc_o(inc_new), .ack_o(ack_new), .ctl_o(ctl_new),
    .mask_o(mask_new)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_SETTLE;
      ST_SETTLE: if (settle_last) st_d = ST_EXEC;
      ST_EXEC:   st_d = ST_FIN;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_NONE;
      clr_q  <= 1'b0;
      addr_q <= '0;
      acc_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) begin
        op_q   <= op_dec;
        clr_q  <= clr_dec;
        addr_q <= instr_i[ADDR_W-1:0];
        acc_q  <= acc_i;
      end
    end
  end

  // results registered at the sampling edge; strobes live for the done cycle only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o    <= '0;
      pc_inc_o <= '0;
      ack_o    <= 1'b0;
      ctl_o    <= 1'b0;
      mask_o   <= 1'b0;
    end else begin
      ack_o  <= (st_q == ST_EXEC) && ack_new;
      ctl_o  <= (st_q == ST_EXEC) && ctl_new;
      mask_o <= (st_q == ST_EXEC) && mask_new;
      if (st_q == ST_EXEC) begin
        acc_o    <= acc_new;
        pc_inc_o <= inc_new;
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FIN);
  assign adb_o  = busy_o ? addr_q : '0;
  assign otb_o  = (busy_o && (op_q == OP_OUT || op_q == OP_MASK)) ? acc_q : '0;
endmodule

// File: rtl/iobus_seq_chk.sv
module iobus_seq_chk #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned SETTLE_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        pc_inc_o,
  input logic [ADDR_W-1:0] adb_o,
  input logic [WORD_W-1:0] otb_o,
  input logic              ack_o,
  input logic              ctl_o,
  input logic              mask_o
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                busy_cnt <= 0;
    else if (!busy_o || done_o) busy_cnt <= 0;
    else                        busy_cnt <= busy_cnt + 1;
  end

  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (adb_o == '0 && otb_o == '0));
  // R1
  adb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(adb_o));
  // R2
  done_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_cnt == SETTLE_CYC + 1));
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  strobe_in_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o || ctl_o || mask_o) |-> done_o);
  // R9
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_o, ctl_o, mask_o}));
  // R3
  ack_skips_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> pc_inc_o == 2'd2);
  // R6
  mask_no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o |-> pc_inc_o == 2'd1);
  // R7
  ctl_no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o |-> pc_inc_o == 2'd1);
  // R8
  inc_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pc_inc_o == 2'd1 || pc_inc_o == 2'd2));
endmodule

bind iobus_seq iobus_seq_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)
) i_iobus_seq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .pc_inc_o(pc_inc_o), .adb_o(adb_o), .otb_o(otb_o), .ack_o(ack_o),
  .ctl_o(ctl_o), .mask_o(mask_o)
);

// File: tb/test_iobus_seq.sv
module test_iobus_seq;
  localparam int SETTLE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, acc_in = '0, inb = '0;
  logic        ready = 1'b0;
  logic        busy, done, ack, ctl, mask;
  logic [15:0] acc_out, otb;
  logic [1:0]  pc_inc;
  logic [9:0]  adb;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  iobus_seq #(.SETTLE_CYC(SETTLE)) i_iobus_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr), .acc_i(acc_in),
    .ready_i(ready), .inb_i(inb), .busy_o(busy), .done_o(done), .acc_o(acc_out),
    .pc_inc_o(pc_inc), .adb_o(adb), .otb_o(otb), .ack_o(ack), .ctl_o(ctl),
    .mask_o(mask)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [5:0] opc, input logic [3:0] fn, input logic [5:0] dev,
                        input logic rdy, input logic [15:0] a, input logic [15:0] b,
                        input bit poke);
    logic [15:0] e_acc, e_otb;
    logic [1:0]  e_inc;
    logic        e_ack, e_ctl, e_mask;
    int          k;
    e_acc = a; e_inc = 2'd1; e_ack = 0; e_ctl = 0; e_mask = 0; e_otb = '0;
    case (opc)
      6'o54: if (rdy) begin e_acc = (fn[3] ? 16'h0 : a) | b; e_inc = 2; e_ack = 1; end // R3 R4
      6'o74: begin
        e_otb = a;
        if (dev == 6'd0) e_mask = 1;                  // R6
        else if (rdy) begin e_inc = 2; e_ack = 1; end // R5
      end
      6'o14: e_ctl = 1;                               // R7
      6'o34: if (rdy) e_inc = 2;                      // R8
      default: ;                                      // R10
    endcase
    @(negedge clk);
    start = 1; instr = {opc, fn, dev}; acc_in = a; inb = b; ready = rdy;
    @(negedge clk);
    start = 0;
    chk(busy, "R2 busy after start", 32'(busy), 1);
    chk(adb == {fn, dev}, "R1 adb", 32'(adb), 32'({fn, dev}));
    chk(otb == e_otb, "R5/R10 otb", 32'(otb), 32'(e_otb));
    if (poke) begin // R11
      start = 1; instr = {6'o54, 4'b1000, 6'd5}; acc_in = ~a;
    end
    k = 1;
    while (!done && k < 20) begin
      chk(!(ack || ctl || mask), "R9 strobe early", 32'({ack, ctl, mask}), 0);
      @(negedge clk);
      start = 0;
      k++;
      if (!done) chk(adb == {fn, dev}, "R1 adb hold", 32'(adb), 32'({fn, dev}));
    end
    chk(k == SETTLE + 2, "R2 done timing", 32'(k), SETTLE + 2);
    chk(acc_out == e_acc, "R3/R4/R10 acc", 32'(acc_out), 32'(e_acc));
    chk(pc_inc == e_inc, "R8 pc_inc", 32'(pc_inc), 32'(e_inc));
    chk({ack, ctl, mask} == {e_ack, e_ctl, e_mask}, "R9 strobes",
        32'({ack, ctl, mask}), 32'({e_ack, e_ctl, e_mask}));
    @(negedge clk);
    chk(!done && !(ack || ctl || mask) && !busy, "R9 one-cycle strobe",
        32'({done, ack, ctl, mask, busy}), 0);
    chk(adb == '0 && otb == '0, "R1 idle bus", 32'({adb, otb}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] opcs[6];
    logic [3:0] fns[3];
    logic [5:0] devs[3];
    int         idx;
    opcs = '{6'o54, 6'o74, 6'o14, 6'o34, 6'o00, 6'o77};
    fns  = '{4'b0000, 4'b1000, 4'b0101};
    devs = '{6'd0, 6'o17, 6'o77};
    repeat (3) @(negedge clk);
    // R12
    chk({busy, done, acc_out, pc_inc, adb, otb, ack, ctl, mask} == '0, "R12 reset",
        32'({busy, done, pc_inc, ack, ctl, mask}), 0);
    rst_n = 1;
    idx = 0;
    foreach (opcs[o]) foreach (fns[f]) foreach (devs[d]) for (int r = 0; r < 2; r++) begin
      run_op(opcs[o], fns[f], devs[d], r[0],
             16'hA5A0 ^ 16'(idx * 16'h0101), 16'h0C3F ^ 16'(idx * 16'h1111), 1'b0);
      idx++;
    end
    // R11: second start during busy must not disturb the first
    run_op(6'o74, 4'b0011, 6'o12, 1'b1, 16'h1234, 16'h00FF, 1'b1);
    run_op(6'o54, 4'b0000, 6'o12, 1'b1, 16'hF000, 16'h000F, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule